// File: doc/BRIEF.md
# Lane-selectable bit error checker

This block tests the link quality of one lane of a four-lane serial receiver in the field. Each lane hands over a 10-bit decoded word together with a valid strobe. When the test is switched on, the block follows the chosen lane's words bit by bit and compares them with a pseudo-random sequence that it predicts from the bits already received. Mismatches are shown on a single active-low result pin. That pin either follows the most recent word or holds a sticky error until it is cleared.

The same pin doubles as a debug monitor. With the monitor switch on, it carries the selected lane's recovered horizontal sync, vertical sync, data enable, or a word-rate toggle that stands in for the recovered clock.

A control state machine has three states. OFF means the test is disabled. SEED means the block is waiting for the first word, which only fills the predictor history. CHECK means words are being compared.

The transitions are:
- OFF to SEED when the test is enabled.
- SEED to CHECK on a valid word from the selected lane.
- SEED or CHECK to SEED when the lane select changes.
- Any state to OFF when the test is disabled.

Top module: `lane_bert`

## Requirements
- R1: While `test_en` is 0 and `mon_en` is 0, `result_n` is 1 whatever data arrives.
- R2: `lane_sel` picks the lane under test in binary (0 selects lane 0, 3 selects lane 3). Data and strobes on the other lanes have no effect on the result.
- R3: Each word is checked LSB first against the rule b[n] = b[n-6] XOR b[n-7] (polynomial x^7+x^6+1), where the earlier bits are the received ones. With `latch_sel` = 0, `result_n` is 0 in the cycle after a word with any mismatch and 1 in the cycle after a clean word. A single flipped bit also disturbs the predictions 6 and 7 bits later.
- R4: The first valid word accepted in SEED state only loads the predictor history and never flags an error, whatever its content.
- R5: With `latch_sel` = 1, any error makes `result_n` 0 and it stays 0 through later clean words.
- R6: While `latch_sel` is 0 the sticky error is cleared. After `latch_sel` returns to 1, `result_n` reads 1 until a new error occurs.
- R7: A change of `lane_sel` during a test returns the checker to SEED and clears both the live and the sticky error, so `result_n` reads 1 in the next cycle.
- R8: Words presented with the valid strobe low are ignored.
- R9: With `mon_en` = 1, `result_n` shows the selected lane's signal picked by `mon_sel`, registered one cycle: 0 horizontal sync, 1 vertical sync, 2 data enable, 3 a toggle that flips on every valid word of that lane. The toggle appears two cycles after the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data | input | 40 | Decoded words, lane k at bits [10k+9:10k] |
| lane_vld | input | 4 | Per-lane word valid strobes |
| lane_hs | input | 4 | Per-lane recovered horizontal sync |
| lane_vs | input | 4 | Per-lane recovered vertical sync |
| lane_de | input | 4 | Per-lane recovered data enable |
| test_en | input | 1 | Error test enable |
| lane_sel | input | 2 | Lane under test / lane monitored |
| latch_sel | input | 1 | 1 shows sticky result, 0 clears it and shows live result |
| mon_en | input | 1 | Monitor mode switch, overrides the test result |
| mon_sel | input | 2 | Monitored signal choice |
| result_n | output | 1 | Active-low error result or monitor signal |

## Verification
The assertions check several behaviours on every cycle:
- The pin stays high while both modes are off.
- SEED state never carries an error.
- The sticky error clears while `latch_sel` is 0, and holds while it is 1 and the lane is unchanged.
- A lane change restarts seeding with a clear latch.

Only the bench's scenarios can show the rest. These are that the predictor flags exactly the corrupted words of the chosen lane and ignores the other lanes and strobe-low cycles, and that a garbage first word is accepted silently. They also cover the monitor path returning the right lane and signal with the right delay.

// File: rtl/lane_bert_pkg.sv
package lane_bert_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SEED  = 2'd1,
        ST_CHECK = 2'd2
    } bert_state_e;

    typedef enum logic [1:0] {
        MON_HS  = 2'd0,
        MON_VS  = 2'd1,
        MON_DE  = 2'd2,
        MON_CLK = 2'd3
    } mon_pick_e;
endpackage

// File: rtl/bert_lane_mux.sv
module bert_lane_mux #(
    parameter int NUM_LANES = 4,
    parameter int WORD_W    = 10,
    localparam int SEL_W    = $clog2(NUM_LANES)
) (
    input  logic [NUM_LANES*WORD_W-1:0] lane_data,
    input  logic [NUM_LANES-1:0]        lane_vld,
    input  logic [SEL_W-1:0]            sel,
    output logic [WORD_W-1:0]           word,
    output logic                        vld
);
    assign word = lane_data[sel*WORD_W +: WORD_W];
    assign vld  = lane_vld[sel];
endmodule

// File: rtl/bert_word_check.sv
module bert_word_check #(
    parameter int WORD_W = 10,
    parameter int SEQ_LEN = 7,
    parameter int SEQ_TAP = 6
) (
    input  logic [SEQ_LEN-1:0] hist,
    input  logic [WORD_W-1:0]  word,
    output logic               err,
    output logic [SEQ_LEN-1:0] hist_nxt
);
    localparam int EXT_W = WORD_W + SEQ_LEN;

    logic [EXT_W-1:0]  ext;
    logic [WORD_W-1:0] miss;

    // hist[0] is the oldest bit; the word follows LSB first
    assign ext = {word, hist};

    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            miss[i] = ext[i+SEQ_LEN] ^ ext[i+SEQ_LEN-SEQ_TAP] ^ ext[i];
        end
    end

    assign err      = |miss;
    assign hist_nxt = ext[EXT_W-1 -: SEQ_LEN];
endmodule

// File: rtl/bert_monitor.sv
module bert_monitor
    import lane_bert_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int SEL_W    = $clog2(NUM_LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_vld,
    input  logic [NUM_LANES-1:0] lane_hs,
    input  logic [NUM_LANES-1:0] lane_vs,
    input  logic [NUM_LANES-1:0] lane_de,
    input  logic [SEL_W-1:0]     sel,
    input  logic [1:0]           pick,
    output logic                 mon_q
);
    logic [NUM_LANES-1:0] tog_q;
    logic                 mon_d;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_tog
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           tog_q[g] <= 1'b0;
            else if (lane_vld[g]) tog_q[g] <= ~tog_q[g];
        end
    end

    always_comb begin
        unique case (mon_pick_e'(pick))
            MON_HS:  mon_d = lane_hs[sel];
            MON_VS:  mon_d = lane_vs[sel];
            MON_DE:  mon_d = lane_de[sel];
            MON_CLK: mon_d = tog_q[sel];
            default: mon_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= 1'b0;
        else        mon_q <= mon_d;
    end
endmodule

// File: rtl/lane_bert.sv
module lane_bert
    import lane_bert_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int WORD_W    = 10,
    parameter int SEQ_LEN   = 7,
    parameter int SEQ_TAP   = 6,
    localparam int SEL_W    = $clog2(NUM_LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES*WORD_W-1:0] lane_data,
    input  logic [NUM_LANES-1:0]        lane_vld,
    input  logic [NUM_LANES-1:0]        lane_hs,
    input  logic [NUM_LANES-1:0]        lane_vs,
    input  logic [NUM_LANES-1:0]        lane_de,
    input  logic                        test_en,
    input  logic [SEL_W-1:0]            lane_sel,
    input  logic                        latch_sel,
    input  logic                        mon_en,
    input  logic [1:0]                  mon_sel,
    output logic                        result_n
);
    bert_state_e          state_q, state_d;
    logic [SEL_W-1:0]     sel_q;
    logic [SEQ_LEN-1:0]   hist_q, hist_nxt;
    logic                 err_q, sticky_q;
    logic [WORD_W-1:0]    w_data;
    logic                 w_vld, w_err, lane_chg, mon_q;

    bert_lane_mux #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_mux (
        .lane_data(lane_data), .lane_vld(lane_vld), .sel(lane_sel),
        .word(w_data), .vld(w_vld)
    );

    bert_word_check #(.WORD_W(WORD_W), .SEQ_LEN(SEQ_LEN), .SEQ_TAP(SEQ_TAP)) u_chk (
        .hist(hist_q), .word(w_data), .err(w_err), .hist_nxt(hist_nxt)
    );

    bert_monitor #(.NUM_LANES(NUM_LANES)) u_mon (
        .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld), .lane_hs(lane_hs),
        .lane_vs(lane_vs), .lane_de(lane_de), .sel(lane_sel), .pick(mon_sel),
        .mon_q(mon_q)
    );

    assign lane_chg = (lane_sel != sel_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (test_en) state_d = ST_SEED;
            ST_SEED:  if (!test_en) state_d = ST_OFF;
                      else if (lane_chg) state_d = ST_SEED;
                      else if (w_vld) state_d = ST_CHECK;
            ST_CHECK: if (!test_en) state_d = ST_OFF;
                      else if (lane_chg) state_d = ST_SEED;
            default:  state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // checker datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            hist_q   <= '0;
            err_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            sel_q <= lane_sel;
            if (state_d == ST_OFF || (state_q != ST_OFF && lane_chg)) begin
                err_q    <= 1'b0;
                sticky_q <= 1'b0;
            end else if (state_q == ST_SEED && w_vld) begin
                hist_q   <= hist_nxt;
                err_q    <= 1'b0;
                sticky_q <= 1'b0;
            end else if (state_q == ST_CHECK && w_vld) begin
                hist_q   <= hist_nxt;
                err_q    <= w_err;
                sticky_q <= latch_sel & (sticky_q | w_err);
            end else begin
                sticky_q <= latch_sel & sticky_q;
            end
        end
    end

    // output
    always_comb begin
        if (mon_en)                result_n = mon_q;
        else if (state_q == ST_OFF) result_n = 1'b1;
        else                       result_n = ~(latch_sel ? sticky_q : err_q);
    end

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && !mon_en) |=> (result_n || mon_en));

    // R4
    seed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED) |-> (!err_q && !sticky_q));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && test_en && !lane_chg && latch_sel && sticky_q) |=> sticky_q);

    // R6
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_sel |=> !sticky_q);

    // R7
    lane_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && test_en && lane_chg) |=> (state_q == ST_SEED && !sticky_q));
endmodule

// File: tb/sim_lane_bert.sv
module sim_lane_bert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] lane_data = '0;
    logic [3:0]  lane_vld = '0, lane_hs = '0, lane_vs = '0, lane_de = '0;
    logic        test_en = 1'b0, latch_sel = 1'b0, mon_en = 1'b0;
    logic [1:0]  lane_sel = '0, mon_sel = '0;
    logic        result_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [6:0] gh = 7'h7F;   // bench stream history, gh[0] oldest

    always #2.5 clk = ~clk;

    lane_bert u0 (
        .clk(clk), .rst_n(rst_n), .lane_data(lane_data), .lane_vld(lane_vld),
        .lane_hs(lane_hs), .lane_vs(lane_vs), .lane_de(lane_de),
        .test_en(test_en), .lane_sel(lane_sel), .latch_sel(latch_sel),
        .mon_en(mon_en), .mon_sel(mon_sel), .result_n(result_n)
    );

    // fields: [11:10] lane, [9] latch, [8:5] corrupted lanes, [4:2] flipped bits,
    // [1] expected result after bad word, [0] expected after next clean word
    localparam logic [11:0] VEC [8] = '{
        {2'd0, 1'b0, 4'b0001, 3'b001, 1'b0, 1'b1},   // R3 live error
        {2'd0, 1'b0, 4'b0000, 3'b000, 1'b1, 1'b1},   // R3 clean
        {2'd1, 1'b1, 4'b0010, 3'b100, 1'b0, 1'b0},   // R5 sticky
        {2'd2, 1'b1, 4'b0010, 3'b010, 1'b1, 1'b1},   // R2 other lane
        {2'd3, 1'b0, 4'b1000, 3'b011, 1'b0, 1'b1},   // R3 lane 3
        {2'd3, 1'b1, 4'b1000, 3'b101, 1'b0, 1'b0},   // R5 lane 3
        {2'd2, 1'b0, 4'b1111, 3'b111, 1'b0, 1'b1},   // R2 all lanes
        {2'd1, 1'b1, 4'b1101, 3'b001, 1'b1, 1'b1}    // R2 others only
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: result_n=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic send_raw(input logic [9:0] w, input logic [3:0] bad, input logic [2:0] bm);
        for (int l = 0; l < 4; l++)
            lane_data[l*10 +: 10] = w ^ (bad[l] ? {7'd0, bm} : 10'd0);
        lane_vld = 4'hF;
        @(negedge clk);
        lane_vld = 4'h0;
    endtask

    task automatic send_word(input logic [3:0] bad, input logic [2:0] bm);
        logic [9:0] w;
        for (int i = 0; i < 10; i++) begin
            w[i] = gh[1] ^ gh[0];
            gh = {w[i], gh[6:1]};
        end
        send_raw(w, bad, bm);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: result_n=%b expected finish", result_n);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic r;
        repeat (3) @(negedge clk);
        chk("R1 reset", result_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", result_n, 1'b1);

        test_en = 1'b1;
        @(negedge clk);
        for (int e = 0; e < 8; e++) begin
            lane_sel  = VEC[e][11:10];
            latch_sel = VEC[e][9];
            @(negedge clk);
            send_word(4'h0, 3'b000);
            send_word(VEC[e][8:5], VEC[e][4:2]);
            chk($sformatf("R3/R5 vec %0d bad word", e), result_n, VEC[e][1]);
            send_word(4'h0, 3'b000);
            chk($sformatf("R2/R5 vec %0d next word", e), result_n, VEC[e][0]);
        end

        // R7: lane change clears sticky
        send_word(4'b0010, 3'b001);
        chk("R7 sticky set", result_n, 1'b0);
        lane_sel = 2'd2;
        @(negedge clk);
        chk("R7 lane change clears", result_n, 1'b1);
        send_word(4'h0, 3'b000);
        send_word(4'h0, 3'b000);
        chk("R7 reseeded clean", result_n, 1'b1);

        // R6: latch clear
        send_word(4'b0100, 3'b010);
        send_word(4'h0, 3'b000);
        chk("R6 sticky held", result_n, 1'b0);
        latch_sel = 1'b0;
        @(negedge clk);
        chk("R6 cleared live", result_n, 1'b1);
        latch_sel = 1'b1;
        @(negedge clk);
        chk("R6 relatch reads clean", result_n, 1'b1);

        // R8: strobe low ignored
        for (int l = 0; l < 4; l++) lane_data[l*10 +: 10] = 10'h155;
        lane_vld = 4'h0;
        repeat (2) @(negedge clk);
        send_word(4'h0, 3'b000);
        chk("R8 invalid words ignored", result_n, 1'b1);

        // R1: disabled test ignores errors
        test_en = 1'b0;
        @(negedge clk);
        send_word(4'hF, 3'b111);
        chk("R1 test off", result_n, 1'b1);

        // R4: garbage seed word
        test_en = 1'b1; lane_sel = 2'd0; latch_sel = 1'b1;
        @(negedge clk);
        send_raw(10'h3C5, 4'h0, 3'b000);
        chk("R4 seed word silent", result_n, 1'b1);
        test_en = 1'b0;
        @(negedge clk);

        // R9: monitor
        mon_en = 1'b1; lane_sel = 2'd2; mon_sel = 2'd0; lane_hs = 4'b0100;
        @(negedge clk);
        chk("R9 hsync high", result_n, 1'b1);
        lane_hs = 4'b1011;
        @(negedge clk);
        chk("R9 hsync lane pick", result_n, 1'b0);
        mon_sel = 2'd1; lane_vs = 4'b0100;
        @(negedge clk);
        chk("R9 vsync", result_n, 1'b1);
        mon_sel = 2'd2; lane_de = 4'b1011;
        @(negedge clk);
        chk("R9 de", result_n, 1'b0);
        mon_sel = 2'd3;
        @(negedge clk);
        r = result_n;
        send_raw(10'h000, 4'h0, 3'b000);
        @(negedge clk);
        chk("R9 clock toggle 1", result_n, ~r);
        send_raw(10'h000, 4'h0, 3'b000);
        @(negedge clk);
        chk("R9 clock toggle 2", result_n, r);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule